// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is an unsigned multiply-accumulate datapath. On every cycle in which `in_valid` is high it takes two N-bit operands and forms their 2N-bit product. It adds that product to a running sum held in a register that is one bit wider than the product. N defaults to 16.

The multiplier works column by column in the vertical-and-crosswise manner. For each output weight it counts the operand bit pairs that land on that weight. It packs the column counts into a few non-overlapping rows and adds the rows with a parallel prefix adder. The accumulation uses a parallel prefix adder of the same kind, 2N+1 bits wide.

The work is split into two register stages: product capture, then accumulation. A small controller with two states, EMPTY and LIVE, decides whether the product is loaded or added. From EMPTY, an accepted product is loaded and the state moves to LIVE. In LIVE, a clear with no valid pair zeroes the sum and returns the state to EMPTY. A clear together with a valid pair reloads the product and the state stays LIVE. Any other cycle adds the product or holds the sum, and the state stays where it is.

Top module: `mac_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `acc_out` becomes zero and `out_valid` becomes low.
- R2: A pair (a, b) accepted together with `clear` produces `acc_out` equal to the exact product a*b, available two cycles later.
- R3: A pair (a, b) accepted without `clear` updates the sum to the previous `acc_out` plus a*b.
- R4: The sum wraps modulo 2^(2N+1); no saturation is applied.
- R5: A cycle with `in_valid` low and `clear` low leaves `acc_out` unchanged two cycles later, and `out_valid` low.
- R6: `clear` takes priority over accumulation. With `in_valid` high, the old sum is discarded and the new product is loaded.
- R7: `clear` with `in_valid` low zeroes `acc_out` two cycles later. Pairs accepted before it are applied first and then discarded.
- R8: `out_valid` equals `in_valid` delayed by exactly two clock cycles.
- R9: `acc_out` is 2N+1 bits wide, and bit 2N keeps the carry out of a sum of two products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Restart the sum with the pair offered in the same cycle |
| in_valid | input | 1 | Operand pair is present |
| op_a | input | N | First operand, unsigned |
| op_b | input | N | Second operand, unsigned |
| acc_out | output | 2N+1 | Running sum |
| out_valid | output | 1 | Sum reflects a newly accepted pair |

## Verification
The bench runs an N=4 instance, where every operand pair can be tried. It loads each of the 256 pairs alone after a clear; a faulty column count or row packing inside the multiplier would show as a wrong single product. It then accumulates all pairs in one run, so the sum wraps many times. A design that dropped the top carry, or saturated, would drift from the 9-bit reference. Clear-only and clear-with-valid cycles are mixed with gaps; a design that ranked accumulation above clear, or mistimed the clear against earlier pairs, would leave a stale sum.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Accumulator controller states.
    typedef enum logic {
        ACC_EMPTY = 1'b0,   // sum is known zero: next product is loaded
        ACC_LIVE  = 1'b1    // sum holds accepted products: next product is added
    } acc_state_t;

endpackage

// File: rtl/ppa_adder.sv
// Log-depth parallel prefix adder (dense prefix tree), modulo 2^W.
module ppa_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam int LV = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0] gen [0:LV];
    logic [W-1:0] prp [0:LV];

    assign gen[0] = a & b;
    assign prp[0] = a ^ b;

    for (genvar l = 0; l < LV; l++) begin : g_level
        localparam int D = 1 << l;
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= D) begin : g_node
                assign gen[l+1][i] = gen[l][i] | (prp[l][i] & gen[l][i-D]);
                assign prp[l+1][i] = prp[l][i] & prp[l][i-D];
            end else begin : g_pass
                assign gen[l+1][i] = gen[l][i];
                assign prp[l+1][i] = prp[l][i];
            end
        end
    end

    assign sum = prp[0] ^ {gen[LV][W-2:0], 1'b0};

endmodule

// File: rtl/ucw_mult.sv
// Vertical-and-crosswise multiplier: per-column bit-pair counts, packed
// into non-overlapping rows, rows summed with prefix adders.
module ucw_mult #(
    parameter int N = 16
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] prod
);
    localparam int PW   = 2 * N;
    localparam int CW   = $clog2(N + 1);
    localparam int NCOL = 2 * N - 1;
    localparam int NR   = CW;

    logic [PW-1:0] rows [0:NR-1];
    logic [PW-1:0] part [0:NR-1];

    always_comb begin
        for (int r = 0; r < NR; r++) rows[r] = '0;
        for (int k = 0; k < NCOL; k++) begin
            logic [CW-1:0] cnt;
            cnt = '0;
            for (int i = 0; i < N; i++) begin
                if ((k - i) >= 0 && (k - i) < N)
                    cnt = cnt + CW'(a[i] & b[k-i]);
            end
            rows[k % NR] = rows[k % NR] | (PW'(cnt) << k);
        end
    end

    assign part[0] = rows[0];

    for (genvar r = 1; r < NR; r++) begin : g_rowsum
        ppa_adder #(.W(PW)) u_add (
            .a   (part[r-1]),
            .b   (rows[r]),
            .sum (part[r])
        );
    end

    assign prod = part[NR-1];

endmodule

// File: rtl/mac_accum.sv
// Accumulation stage: controller plus prefix adder and sum register.
module mac_accum
    import mac_pkg::*;
#(
    parameter int PW = 32,
    parameter int AW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stg_valid,
    input  logic          stg_clear,
    input  logic [PW-1:0] stg_prod,
    output logic [AW-1:0] acc,
    output logic          acc_valid
);
    acc_state_t    state_q, state_d;
    logic [AW-1:0] prod_w, add_w, acc_d;

    assign prod_w = AW'(stg_prod);

    ppa_adder #(.W(AW)) u_acc_add (
        .a   (acc),
        .b   (prod_w),
        .sum (add_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        acc_d   = acc;
        unique case (state_q)
            ACC_EMPTY: begin
                if (stg_valid) begin
                    acc_d   = prod_w;
                    state_d = ACC_LIVE;
                end else begin
                    acc_d   = '0;
                end
            end
            ACC_LIVE: begin
                if (stg_clear && stg_valid) begin
                    acc_d = prod_w;
                end else if (stg_clear) begin
                    acc_d   = '0;
                    state_d = ACC_EMPTY;
                end else if (stg_valid) begin
                    acc_d = add_w;
                end
            end
            default: begin
                acc_d   = '0;
                state_d = ACC_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            acc_valid <= 1'b0;
        end else begin
            acc       <= acc_d;
            acc_valid <= stg_valid;
        end
    end

endmodule

// File: rtl/mac_unit.sv
// Two-stage multiply-accumulate top.
module mac_unit #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         in_valid,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic [2*N:0] acc_out,
    output logic         out_valid
);
    localparam int PW = 2 * N;
    localparam int AW = PW + 1;

    logic [PW-1:0] prod_c, prod_q;
    logic          v_q, clr_q;

    ucw_mult #(.N(N)) u_mult (
        .a    (op_a),
        .b    (op_b),
        .prod (prod_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            v_q   <= in_valid;
            clr_q <= clear;
        end
    end

    always_ff @(posedge clk) begin
        prod_q <= prod_c;
    end

    mac_accum #(.PW(PW), .AW(AW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .stg_valid (v_q),
        .stg_clear (clr_q),
        .stg_prod  (prod_q),
        .acc       (acc_out),
        .acc_valid (out_valid)
    );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clear,
    input logic         in_valid,
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic [2*N:0] acc_out,
    input logic         out_valid
);
    localparam int AW = 2 * N + 1;

    logic [1:0] since;
    logic       primed = 1'b0;
    logic       warm;

    always_ff @(posedge clk) primed <= 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n)              since <= 2'd0;
        else if (since != 2'd3)  since <= since + 2'd1;
    end

    assign warm = (since >= 2'd2);

    function automatic logic [AW-1:0] wide_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        return AW'(x) * AW'(y);
    endfunction

    p_reset_r1: assert property (@(posedge clk)
        (primed && !$past(rst_n)) |-> (acc_out == '0 && !out_valid));

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 2)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(in_valid, 2) && !$past(clear, 2)) |-> $stable(acc_out));

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(clear, 2) && $past(in_valid, 2))
        |-> (acc_out == wide_mul($past(op_a, 2), $past(op_b, 2))));

    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(clear, 2) && !$past(in_valid, 2)) |-> (acc_out == '0));

    p_accum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(clear, 2) && $past(in_valid, 2))
        |-> (acc_out == AW'($past(acc_out) + wide_mul($past(op_a, 2), $past(op_b, 2)))));

endmodule

bind mac_unit mac_unit_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .acc_out   (acc_out),
    .out_valid (out_valid)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
    localparam int NB  = 4;
    localparam int AWB = 2 * NB + 1;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          in_valid = 1'b0;
    logic [NB-1:0] op_a = '0;
    logic [NB-1:0] op_b = '0;
    logic [AWB-1:0] acc_out;
    logic          out_valid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // bench-side expectation pipeline (two cycles of latency)
    logic [AWB-1:0] model = '0;
    logic [AWB-1:0] er1 = '0, er2 = '0;
    logic           ev1 = 1'b0, ev2 = 1'b0;
    string          et1 = "R1", et2 = "R1";

    always #10 clk = ~clk;   // 50 MHz

    mac_unit #(.N(NB)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .acc_out   (acc_out),
        .out_valid (out_valid)
    );

    always @(posedge clk) cycles <= cycles + 1;

    task automatic check_acc(input string tag, input logic [AWB-1:0] exp_acc, input logic exp_v);
        checks++;
        if (acc_out !== exp_acc || out_valid !== exp_v) begin
            fails++;
            $display("FAIL %s: acc=%0d valid=%0b expected acc=%0d valid=%0b",
                     tag, acc_out, out_valid, exp_acc, exp_v);
        end
    endtask

    // Called at a negative edge: checks the result of the pair driven two
    // steps earlier, then drives a new pair for the next rising edge.
    task automatic step(input logic [NB-1:0] a, input logic [NB-1:0] b,
                        input logic v, input logic c, input string tag);
        check_acc(et2, er2, ev2);
        er2 = er1; ev2 = ev1; et2 = et1;
        if (c)       model = v ? (AWB'(a) * AWB'(b)) : '0;
        else if (v)  model = model + AWB'(a) * AWB'(b);
        er1 = model; ev1 = v; et1 = tag;
        op_a = a; op_b = b; in_valid = v; clear = c;
        @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) step('0, '0, 1'b0, 1'b0, "R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held in reset
        check_acc("R1", '0, 1'b0);
        rst_n = 1'b1;

        // R2 / R6: every pair loaded alone with clear
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                step(NB'(a), NB'(b), 1'b1, 1'b1, "R2");
        drain();

        // R3 / R4: all pairs accumulated in one run, wrapping many times
        step('0, '0, 1'b0, 1'b1, "R7");
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                step(NB'(a), NB'(b), 1'b1, 1'b0, (a > 8) ? "R4" : "R3");
        drain();

        // R9: two maximum products set the top carry bit (225+225=450)
        step(4'hF, 4'hF, 1'b1, 1'b1, "R9");
        step(4'hF, 4'hF, 1'b1, 1'b0, "R9");
        drain();
        checks++;
        if (acc_out[AWB-1] !== 1'b1) begin
            fails++;
            $display("FAIL R9: top bit=%0b expected 1", acc_out[AWB-1]);
        end

        // R5 / R8: valid every other cycle, sum must hold in gaps
        for (int i = 1; i < 12; i++) begin
            step(NB'(i), NB'(i + 3), 1'b1, 1'b0, "R8");
            step(NB'(i + 5), NB'(i), 1'b0, 1'b0, "R5");
        end

        // R7: clear without valid, pairs before it applied then dropped
        step(4'd7, 4'd9, 1'b1, 1'b0, "R3");
        step(4'd3, 4'd3, 1'b0, 1'b1, "R7");
        step(4'd2, 4'd5, 1'b1, 1'b0, "R7");
        step(4'd6, 4'd6, 1'b1, 1'b0, "R3");
        // R6: clear with valid mid-run discards old sum
        step(4'd11, 4'd13, 1'b1, 1'b1, "R6");
        step(4'd1, 4'd1, 1'b1, 1'b0, "R6");
        step(4'd0, 4'd0, 1'b0, 1'b1, "R7");
        step(4'd0, 4'd0, 1'b0, 1'b1, "R7");
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule